// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle 32-bit processor whose datapath shares one memory between instruction fetch and data access. Each instruction is walked through a short series of states. The first fetches the instruction and advances the PC. The second decodes the instruction while the ALU precomputes a branch target. The remaining states are an execute or address step, an optional memory step and an optional register write-back step. In every state the block drives the select codes and write strobes that steer the datapath.

The controller reads the opcode and function fields from the instruction register, the ALU zero flag and bit 31 of the ALU result. It is built in three parts: an instruction classifier, a sequencer that holds the state register and its next-state logic, and a strobe generator that maps the state, and where needed the instruction, to the datapath controls. Every control output is 0 unless the current state drives it.

Top module: `mc_control`

## Requirements
- R1: An active-high `rst` places the controller in the fetch state at once, without waiting for a clock edge. While `rst` is high the fetch controls of R2 are presented. The first state after reset is fetch.
- R2: The fetch state drives `instDataSel`=0, `memRead`=1, `irWrite`=1, `aluSrcX`=0, `aluSrcY`=0, `aluFunc`=0 (add), `pcSrc`=3 and `pcWrite`=1. All other outputs are 0. The next state is always the decode state.
- R3: The decode state drives `aluSrcX`=0, `aluSrcY`=3 and `aluFunc`=0, with all other outputs 0. Its next state depends on the instruction class: ALU execute, memory address, or jump/branch.
- R4: A load (opcode 6'h23) takes 5 cycles. After fetch and decode come three states. The address state drives `aluSrcX`=1, `aluSrcY`=2 and add. The read state drives `instDataSel`=1 and `memRead`=1. The write-back state drives `regDst`=0, `regInSel`=0 and `regWrite`=1. Fetch follows.
- R5: A store (opcode 6'h2B) takes 4 cycles. After fetch and decode come the address state of R4 and then a write state that drives `instDataSel`=1 and `memWrite`=1. Fetch follows.
- R6: Register-form ALU instructions have opcode 6'h00 and function bits [5:3]=3'b100. They take 4 cycles. The execute state drives `aluSrcX`=1, `aluSrcY`=1 and `aluFunc`=function[2:0]. The ALU function codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 set-less-than and 7 load-upper. The write-back state drives `regDst`=1, `regInSel`=1 and `regWrite`=1.
- R7: Immediate-form ALU instructions have opcode bits [5:3]=3'b001. They take 4 cycles. The execute state drives `aluSrcX`=1, `aluSrcY`=2 and `aluFunc`=opcode[2:0]. The write-back state drives `regDst`=0, `regInSel`=1 and `regWrite`=1.
- R8: Jumps take 3 cycles, and in the jump/branch state they drive `pcWrite`=1.
  - A direct jump (opcode 6'h02) drives `jumpSel`=0 and `pcSrc`=0.
  - A jump-and-link (opcode 6'h03) does the same and also drives `regDst`=2, `regInSel`=1 and `regWrite`=1.
  - A register jump (opcode 6'h00, function 6'h08) drives `pcSrc`=1.
  - A system call (opcode 6'h00, function 6'h0C) drives `jumpSel`=1 and `pcSrc`=0.
- R9: Conditional branches take 3 cycles. In the jump/branch state they drive `pcSrc`=2, `aluSrcX`=1, `aluSrcY`=1 and `aluFunc`=1 (subtract). `pcWrite` follows the opcode:
  - equal (6'h04): `pcWrite` equals `aluZero`;
  - not-equal (6'h05): `pcWrite` equals the inverse of `aluZero`;
  - less-than-zero (6'h01): `pcWrite` equals `aluSign`.
- R10: Any other opcode/function combination is illegal. After the decode state the controller returns to fetch (2 cycles) and asserts no write strobe.
- R11: `memRead` and `memWrite` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| aluZero | input | 1 | ALU result is zero |
| aluSign | input | 1 | Bit 31 of the ALU result |
| pcSrc | output | 2 | PC source select |
| pcWrite | output | 1 | PC write enable |
| jumpSel | output | 1 | Jump address select (0 target field, 1 system-call vector) |
| instDataSel | output | 1 | Memory address select (0 PC, 1 ALU result) |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register write enable |
| regDst | output | 2 | Register destination select |
| regInSel | output | 1 | Register write data select (0 memory, 1 ALU/PC) |
| regWrite | output | 1 | Register file write enable |
| aluSrcX | output | 1 | ALU X operand select |
| aluSrcY | output | 2 | ALU Y operand select |
| aluFunc | output | 3 | ALU operation code |

## Verification
Two functions share a single cycle in this block. In the jump-and-link state the PC write and the return-address register write happen together. In the conditional-branch state the subtract compare setup happens together with a PC write that depends on the flags. The first case is provoked by a jump-and-link instruction, and the bench requires both strobe groups in that one state. The second case is provoked by driving the zero flag and the sign flag high together, which shows that each branch kind looks only at its own flag: not-equal must then not write the PC, and less-than-zero must write it.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 3;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OP_BLTZ    = 6'h01;
  localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OP_W-1:0] OP_JLINK   = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE     = 6'h05;
  localparam logic [OP_W-1:0] OP_LOAD    = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE   = 6'h2B;
  localparam logic [FN_W-1:0] FN_JREG    = 6'h08;
  localparam logic [FN_W-1:0] FN_SYSC    = 6'h0C;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'd0;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'd1;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MEMADR = 4'd2,
    S_MEMRD  = 4'd3,
    S_LOADWB = 4'd4,
    S_JUMPBR = 4'd5,
    S_MEMWR  = 4'd6,
    S_ALUEX  = 4'd7,
    S_ALUWB  = 4'd8
  } state_t;

  typedef enum logic [3:0] {
    K_ILLEGAL, K_ALUREG, K_ALUIMM, K_LOAD, K_STORE, K_JUMP,
    K_JLINK, K_JREG, K_SYSC, K_BEQ, K_BNE, K_BLTZ
  } kind_t;

  typedef struct packed {
    kind_t            kind;
    logic [ALU_W-1:0] aluOp;
  } decoded_t;

  typedef struct packed {
    logic [1:0]       pcSrc;
    logic             pcWrite;
    logic             jumpSel;
    logic             instDataSel;
    logic             memRead;
    logic             memWrite;
    logic             irWrite;
    logic [1:0]       regDst;
    logic             regInSel;
    logic             regWrite;
    logic             aluSrcX;
    logic [1:0]       aluSrcY;
    logic [ALU_W-1:0] aluFunc;
  } strobes_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output decoded_t        dec
);
  localparam int FN_HI = FN_W - 1;
  localparam int OP_HI = OP_W - 1;

  always_comb begin
    dec.kind  = K_ILLEGAL;
    dec.aluOp = ALU_ADD;
    case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JREG) dec.kind = K_JREG;
        else if (funct == FN_SYSC) dec.kind = K_SYSC;
        else if (funct[FN_HI -: 3] == 3'b100) begin
          dec.kind  = K_ALUREG;
          dec.aluOp = funct[ALU_W-1:0];
        end
      end
      OP_BLTZ:  dec.kind = K_BLTZ;
      OP_JUMP:  dec.kind = K_JUMP;
      OP_JLINK: dec.kind = K_JLINK;
      OP_BEQ:   dec.kind = K_BEQ;
      OP_BNE:   dec.kind = K_BNE;
      OP_LOAD:  dec.kind = K_LOAD;
      OP_STORE: dec.kind = K_STORE;
      default: begin
        if (opcode[OP_HI -: 3] == 3'b001) begin
          dec.kind  = K_ALUIMM;
          dec.aluOp = opcode[ALU_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  kind_t  kind,
  output state_t state
);
  state_t nextState;

  always_comb begin
    nextState = S_FETCH;
    case (state)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        case (kind)
          K_ALUREG, K_ALUIMM: nextState = S_ALUEX;
          K_LOAD, K_STORE:    nextState = S_MEMADR;
          K_JUMP, K_JLINK, K_JREG, K_SYSC,
          K_BEQ, K_BNE, K_BLTZ: nextState = S_JUMPBR;
          default:            nextState = S_FETCH;
        endcase
      end
      S_MEMADR: begin
        if (kind == K_STORE)     nextState = S_MEMWR;
        else if (kind == K_LOAD) nextState = S_MEMRD;
        else                     nextState = S_FETCH;
      end
      S_MEMRD:  nextState = S_LOADWB;
      S_LOADWB: nextState = S_FETCH;
      S_MEMWR:  nextState = S_FETCH;
      S_ALUEX:  nextState = S_ALUWB;
      S_ALUWB:  nextState = S_FETCH;
      S_JUMPBR: nextState = S_FETCH;
      default:  nextState = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= S_FETCH;
    else     state <= nextState;
  end

  // R1
  resetFetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == S_FETCH));
endmodule

// File: rtl/mc_strobes.sv
module mc_strobes
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  state_t   state,
  input  decoded_t dec,
  input  logic     aluZero,
  input  logic     aluSign,
  output strobes_t s
);
  always_comb begin
    s = '0;
    case (state)
      S_FETCH: begin
        s.memRead = 1'b1;
        s.irWrite = 1'b1;
        s.aluFunc = ALU_ADD;
        s.pcSrc   = 2'd3;
        s.pcWrite = 1'b1;
      end
      S_DECODE: begin
        s.aluSrcY = 2'd3;
        s.aluFunc = ALU_ADD;
      end
      S_MEMADR: begin
        s.aluSrcX = 1'b1;
        s.aluSrcY = 2'd2;
        s.aluFunc = ALU_ADD;
      end
      S_MEMRD: begin
        s.instDataSel = 1'b1;
        s.memRead     = 1'b1;
      end
      S_LOADWB: begin
        s.regDst   = 2'd0;
        s.regInSel = 1'b0;
        s.regWrite = 1'b1;
      end
      S_MEMWR: begin
        s.instDataSel = 1'b1;
        s.memWrite    = 1'b1;
      end
      S_ALUEX: begin
        s.aluSrcX = 1'b1;
        s.aluSrcY = (dec.kind == K_ALUREG) ? 2'd1 : 2'd2;
        s.aluFunc = dec.aluOp;
      end
      S_ALUWB: begin
        s.regDst   = (dec.kind == K_ALUREG) ? 2'd1 : 2'd0;
        s.regInSel = 1'b1;
        s.regWrite = 1'b1;
      end
      S_JUMPBR: begin
        case (dec.kind)
          K_JUMP: begin
            s.jumpSel = 1'b0;
            s.pcSrc   = 2'd0;
            s.pcWrite = 1'b1;
          end
          K_JLINK: begin
            s.jumpSel  = 1'b0;
            s.pcSrc    = 2'd0;
            s.pcWrite  = 1'b1;
            s.regDst   = 2'd2;
            s.regInSel = 1'b1;
            s.regWrite = 1'b1;
          end
          K_JREG: begin
            s.pcSrc   = 2'd1;
            s.pcWrite = 1'b1;
          end
          K_SYSC: begin
            s.jumpSel = 1'b1;
            s.pcSrc   = 2'd0;
            s.pcWrite = 1'b1;
          end
          K_BEQ, K_BNE, K_BLTZ: begin
            s.pcSrc   = 2'd2;
            s.aluSrcX = 1'b1;
            s.aluSrcY = 2'd1;
            s.aluFunc = ALU_SUB;
            case (dec.kind)
              K_BEQ:   s.pcWrite = aluZero;
              K_BNE:   s.pcWrite = ~aluZero;
              default: s.pcWrite = aluSign;
            endcase
          end
          default: s = '0;
        endcase
      end
      default: s = '0;
    endcase
  end

  // R11
  memExclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(s.memRead && s.memWrite));

  // R3
  decodeAfterFetch_chk: assert property (@(posedge clk) disable iff (rst)
    s.irWrite |=> (s.aluSrcY == 2'd3 && !s.pcWrite && !s.irWrite));

  // R5
  storeEnds_chk: assert property (@(posedge clk) disable iff (rst)
    s.memWrite |=> s.irWrite);

  // R4
  loadWbEnds_chk: assert property (@(posedge clk) disable iff (rst)
    (s.regWrite && !s.regInSel) |=> s.irWrite);
endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             aluZero,
  input  logic             aluSign,
  output logic [1:0]       pcSrc,
  output logic             pcWrite,
  output logic             jumpSel,
  output logic             instDataSel,
  output logic             memRead,
  output logic             memWrite,
  output logic             irWrite,
  output logic [1:0]       regDst,
  output logic             regInSel,
  output logic             regWrite,
  output logic             aluSrcX,
  output logic [1:0]       aluSrcY,
  output logic [ALU_W-1:0] aluFunc
);
  decoded_t dec;
  state_t   state;
  strobes_t strb;

  mc_decode u_decode (
    .opcode (opcode),
    .funct  (funct),
    .dec    (dec)
  );

  mc_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .kind  (dec.kind),
    .state (state)
  );

  mc_strobes u_strobes (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .dec     (dec),
    .aluZero (aluZero),
    .aluSign (aluSign),
    .s       (strb)
  );

  assign pcSrc       = strb.pcSrc;
  assign pcWrite     = strb.pcWrite;
  assign jumpSel     = strb.jumpSel;
  assign instDataSel = strb.instDataSel;
  assign memRead     = strb.memRead;
  assign memWrite    = strb.memWrite;
  assign irWrite     = strb.irWrite;
  assign regDst      = strb.regDst;
  assign regInSel    = strb.regInSel;
  assign regWrite    = strb.regWrite;
  assign aluSrcX     = strb.aluSrcX;
  assign aluSrcY     = strb.aluSrcY;
  assign aluFunc     = strb.aluFunc;
endmodule

// File: tb/tb_mc_control.sv
module tb_mc_control;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic aluZero = 1'b0;
  logic aluSign = 1'b0;
  logic [1:0] pcSrc, regDst, aluSrcY;
  logic pcWrite, jumpSel, instDataSel, memRead, memWrite, irWrite;
  logic regInSel, regWrite, aluSrcX;
  logic [2:0] aluFunc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mc_control dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .aluZero(aluZero), .aluSign(aluSign), .pcSrc(pcSrc), .pcWrite(pcWrite),
    .jumpSel(jumpSel), .instDataSel(instDataSel), .memRead(memRead),
    .memWrite(memWrite), .irWrite(irWrite), .regDst(regDst),
    .regInSel(regInSel), .regWrite(regWrite), .aluSrcX(aluSrcX),
    .aluSrcY(aluSrcY), .aluFunc(aluFunc)
  );

  function automatic logic [17:0] v(input logic [1:0] ps, input logic pw,
      input logic js, input logic ids, input logic mr, input logic mw,
      input logic ir, input logic [1:0] rd, input logic ri, input logic rw,
      input logic x, input logic [1:0] y, input logic [2:0] f);
    return {ps, pw, js, ids, mr, mw, ir, rd, ri, rw, x, y, f};
  endfunction

  wire [17:0] obs = {pcSrc, pcWrite, jumpSel, instDataSel, memRead, memWrite,
                     irWrite, regDst, regInSel, regWrite, aluSrcX, aluSrcY, aluFunc};

  localparam logic [17:0] E_FETCH  = {2'd3,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,2'd0,3'd0};
  localparam logic [17:0] E_DECODE = {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd3,3'd0};
  localparam logic [17:0] E_MADR   = {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd2,3'd0};
  localparam logic [17:0] E_MRD    = {2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,3'd0};
  localparam logic [17:0] E_LWB    = {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,2'd0,3'd0};
  localparam logic [17:0] E_MWR    = {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,3'd0};

  task automatic chk(input string tag, input logic [17:0] exp);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, obs, exp);
    end
  endtask

  task automatic step(input string tag, input logic [17:0] exp);
    @(negedge clk);
    chk(tag, exp);
  endtask

  task automatic setInstr(input logic [5:0] op, input logic [5:0] fn,
                          input logic z, input logic sg);
    opcode = op; funct = fn; aluZero = z; aluSign = sg;
    chk("R2 fetch", E_FETCH);
  endtask

  task automatic tReset();
    #5;
    chk("R1 fetch while in reset", E_FETCH);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 fetch after reset release", E_FETCH);
  endtask

  task automatic tLoad();
    setInstr(6'h23, 6'h00, 1'b0, 1'b0);
    step("R3 decode", E_DECODE);
    step("R4 load address", E_MADR);
    step("R4 load read", E_MRD);
    step("R4 load writeback", E_LWB);
    step("R4 back to fetch", E_FETCH);
  endtask

  task automatic tStore();
    setInstr(6'h2B, 6'h00, 1'b0, 1'b0);
    step("R3 decode", E_DECODE);
    step("R5 store address", E_MADR);
    step("R5 store write", E_MWR);
    checks++;
    if (memRead && memWrite) begin
      errors++;
      $display("FAIL R11: actual memRead=%b memWrite=%b expected not both", memRead, memWrite);
    end
    step("R5 back to fetch", E_FETCH);
  endtask

  task automatic tAluReg(input logic [5:0] fn);
    setInstr(6'h00, fn, 1'b0, 1'b0);
    step("R3 decode", E_DECODE);
    step("R6 reg execute", v(0,0,0,0,0,0,0,0,0,0,1,2'd1,fn[2:0]));
    step("R6 reg writeback", v(0,0,0,0,0,0,0,2'd1,1,1,0,0,0));
    step("R6 back to fetch", E_FETCH);
  endtask

  task automatic tAluImm(input logic [5:0] op);
    setInstr(op, 6'h00, 1'b0, 1'b0);
    step("R3 decode", E_DECODE);
    step("R7 imm execute", v(0,0,0,0,0,0,0,0,0,0,1,2'd2,op[2:0]));
    step("R7 imm writeback", v(0,0,0,0,0,0,0,2'd0,1,1,0,0,0));
    step("R7 back to fetch", E_FETCH);
  endtask

  task automatic tJump(input string tag, input logic [5:0] op,
                       input logic [5:0] fn, input logic [17:0] exp);
    setInstr(op, fn, 1'b1, 1'b1);
    step("R3 decode", E_DECODE);
    step(tag, exp);
    step("R8 back to fetch", E_FETCH);
  endtask

  task automatic tBranch(input string tag, input logic [5:0] op,
                         input logic z, input logic sg, input logic pw);
    setInstr(op, 6'h00, z, sg);
    step("R3 decode", E_DECODE);
    step(tag, v(2'd2,pw,0,0,0,0,0,0,0,0,1,2'd1,3'd1));
    step("R9 back to fetch", E_FETCH);
  endtask

  task automatic tIllegal(input logic [5:0] op, input logic [5:0] fn);
    setInstr(op, fn, 1'b0, 1'b0);
    step("R10 decode", E_DECODE);
    step("R10 illegal returns to fetch", E_FETCH);
  endtask

  task automatic tMidReset();
    setInstr(6'h23, 6'h00, 1'b0, 1'b0);
    step("R3 decode", E_DECODE);
    step("R4 load address", E_MADR);
    rst = 1'b1;
    #2;
    chk("R1 asynchronous reset to fetch", E_FETCH);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 fetch after mid reset", E_FETCH);
    step("R3 decode", E_DECODE);
    step("R4 load address", E_MADR);
    step("R4 load read", E_MRD);
    step("R4 load writeback", E_LWB);
    step("R4 back to fetch", E_FETCH);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tLoad();
    tStore();
    tAluReg(6'h22);
    tAluReg(6'h27);
    tAluImm(6'h0D);
    tAluImm(6'h08);
    tJump("R8 direct jump", 6'h02, 6'h00, v(2'd0,1,0,0,0,0,0,0,0,0,0,0,0));
    tJump("R8 jump and link", 6'h03, 6'h00, v(2'd0,1,0,0,0,0,0,2'd2,1,1,0,0,0));
    tJump("R8 register jump", 6'h00, 6'h08, v(2'd1,1,0,0,0,0,0,0,0,0,0,0,0));
    tJump("R8 system call", 6'h00, 6'h0C, v(2'd0,1,1,0,0,0,0,0,0,0,0,0,0));
    tBranch("R9 equal taken", 6'h04, 1'b1, 1'b0, 1'b1);
    tBranch("R9 equal not taken", 6'h04, 1'b0, 1'b1, 1'b0);
    tBranch("R9 not-equal taken", 6'h05, 1'b0, 1'b0, 1'b1);
    tBranch("R9 not-equal both flags", 6'h05, 1'b1, 1'b1, 1'b0);
    tBranch("R9 less-than-zero taken", 6'h01, 1'b1, 1'b1, 1'b1);
    tBranch("R9 less-than-zero zero only", 6'h01, 1'b1, 1'b0, 1'b0);
    tIllegal(6'h3F, 6'h00);
    tIllegal(6'h00, 6'h01);
    tMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule